// File: doc/BRIEF.md
# Per-Processor Interrupt Priority Selector

This block picks, for each of several processors, the most urgent interrupt that is both enabled and pending for that processor, and decides whether the processor's interrupt request line should be raised. Every interrupt has one shared 8-bit priority. A smaller value is more urgent. Each processor has its own enable and pending vectors, its own priority mask and its own running priority. A global distribution enable and a per-processor interface enable gate everything.

A sweep counter visits one interrupt ID per clock cycle. It serves all processors in parallel, so the comparison logic is one comparator per processor and not a tree. At the end of each sweep the winners pass through two thresholds. The mask decides whether a winner is reported at all. The running priority decides whether the reported winner also raises the line. The results are then loaded into the output registers. A one-cycle pulse marks each load, and a sticky flag shows that at least one full sweep has completed since reset.

Top module: `irq_prio_select`

## Requirements
- R1: Among the interrupts `i` with `irq_enable[p*NUM_IRQ+i]` and `irq_pending[p*NUM_IRQ+i]` both set, processor `p` reports the one with the smallest priority value `irq_prio[i*8 +: 8]`, in field `best_id[p*10 +: 10]`.
- R2: When several qualifying interrupts share the smallest priority value, the lowest interrupt ID is reported.
- R3: When no interrupt qualifies for processor `p`, its reported ID is 1023 and `irq_req[p]` is low.
- R4: A winner is reported only if its priority is strictly less than `prio_mask[p*8 +: 8]`. Otherwise the ID is 1023 and `irq_req[p]` is low.
- R5: A reported winner raises `irq_req[p]` only if its priority is strictly less than `run_prio[p*9 +: 9]`. If its priority is equal or greater, the ID is still reported but the line stays low.
- R6: A running priority of 0x100 is the idle value, so any unmasked winner raises the line.
- R7: When `dist_en` is low, or `proc_en[p]` is low, processor `p` reports 1023 and `irq_req[p]` is low.
- R8: Each processor is evaluated independently from its own vectors, mask and running priority.
- R9: The outputs change only on the cycles in which `scan_done` is high. These loads come exactly NUM_IRQ cycles apart. A load reflects the inputs whenever those inputs were held stable for the whole preceding sweep, so any change is reflected within 2*NUM_IRQ+1 cycles.
- R10: While reset is active, and until the first load, every ID is 1023, every request line is low and `result_valid` is low. `result_valid` goes high at the first load and stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dist_en | input | 1 | Global distribution enable |
| proc_en | input | NUM_PROC | Per-processor interface enable |
| irq_enable | input | NUM_PROC*NUM_IRQ | Enable bits, processor p at bits p*NUM_IRQ+i |
| irq_pending | input | NUM_PROC*NUM_IRQ | Pending bits, same layout as irq_enable |
| irq_prio | input | NUM_IRQ*8 | Priority of interrupt i at bits i*8 +: 8 |
| prio_mask | input | NUM_PROC*8 | Priority mask of processor p at p*8 +: 8 |
| run_prio | input | NUM_PROC*9 | Running priority of processor p at p*9 +: 9, 0x100 means idle |
| best_id | output | NUM_PROC*10 | Reported interrupt ID per processor, 1023 when none |
| irq_req | output | NUM_PROC | Interrupt request line per processor |
| scan_done | output | 1 | One-cycle pulse in the cycle the outputs were loaded |
| result_valid | output | 1 | High once the first sweep has completed |

## Verification
The assertions rely on no assumption about the inputs, except that they check the gating rule against the enable value sampled on the load edge. This matches the way the design applies the enables: they are applied at load time, not during the sweep. Only the end-to-end comparisons against the bench model depend on the inputs staying stable. For that reason the stimulus changes the inputs only on falling edges and then waits for two load pulses before it compares. Random priorities are drawn from a narrow range to force ties. The masks and running priorities are often set equal to a likely winning priority, so that the strict comparisons are exercised.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int PRIO_W = 8;
  localparam int RUN_W  = PRIO_W + 1;
  localparam int ID_W   = 10;
  localparam logic [ID_W-1:0]  SPUR_ID  = 10'd1023;
  localparam logic [RUN_W-1:0] IDLE_RUN = 9'h100;
endpackage

// File: rtl/irq_scan_ctrl.sv
module irq_scan_ctrl #(
  parameter int NUM_IRQ = 64,
  localparam int CNT_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             first,
  output logic             last
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NUM_IRQ - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign first = (cnt_q == '0);
  assign last  = (cnt_q == LAST_CNT);
  assign cnt   = cnt_q;

  always_comb begin
    if (last) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/irq_best_track.sv
module irq_best_track
  import irq_sel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first,
  input  logic              cand,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic [ID_W-1:0]   cand_id,
  output logic [RUN_W-1:0]  win_prio,
  output logic [ID_W-1:0]   win_id
);
  logic [RUN_W-1:0] best_prio_q;
  logic [ID_W-1:0]  best_id_q;
  logic [RUN_W-1:0] base_prio;
  logic [ID_W-1:0]  base_id;
  logic             take;

  always_comb begin
    base_prio = first ? IDLE_RUN : best_prio_q;
    base_id   = first ? SPUR_ID  : best_id_q;
    take      = cand && ({1'b0, cand_prio} < base_prio);
    win_prio  = take ? {1'b0, cand_prio} : base_prio;
    win_id    = take ? cand_id : base_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_prio_q <= IDLE_RUN;
      best_id_q   <= SPUR_ID;
    end else begin
      best_prio_q <= win_prio;
      best_id_q   <= win_id;
    end
  end
endmodule

// File: rtl/irq_req_gate.sv
module irq_req_gate
  import irq_sel_pkg::*;
(
  input  logic              allow,
  input  logic [RUN_W-1:0]  win_prio,
  input  logic [ID_W-1:0]   win_id,
  input  logic [PRIO_W-1:0] mask,
  input  logic [RUN_W-1:0]  run,
  output logic [ID_W-1:0]   out_id,
  output logic              out_req
);
  logic unmasked;

  always_comb begin
    unmasked = allow && (win_prio < {1'b0, mask});
    out_id   = unmasked ? win_id : SPUR_ID;
    out_req  = unmasked && (win_prio < run);
  end
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irq_sel_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int NUM_PROC = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       dist_en,
  input  logic [NUM_PROC-1:0]        proc_en,
  input  logic [NUM_PROC*NUM_IRQ-1:0] irq_enable,
  input  logic [NUM_PROC*NUM_IRQ-1:0] irq_pending,
  input  logic [NUM_IRQ*PRIO_W-1:0]  irq_prio,
  input  logic [NUM_PROC*PRIO_W-1:0] prio_mask,
  input  logic [NUM_PROC*RUN_W-1:0]  run_prio,
  output logic [NUM_PROC*ID_W-1:0]   best_id,
  output logic [NUM_PROC-1:0]        irq_req,
  output logic                       scan_done,
  output logic                       result_valid
);
  localparam int CNT_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic [CNT_W-1:0]  cnt;
  logic              first, last;
  logic [PRIO_W-1:0] cur_prio;
  logic [ID_W-1:0]   cur_id;

  irq_scan_ctrl #(.NUM_IRQ(NUM_IRQ)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_s2_q),
    .cnt   (cnt),
    .first (first),
    .last  (last)
  );

  assign cur_prio = irq_prio[cnt*PRIO_W +: PRIO_W];
  assign cur_id   = ID_W'(cnt);

  logic [NUM_PROC*ID_W-1:0] gate_id;
  logic [NUM_PROC-1:0]      gate_req;

  for (genvar p = 0; p < NUM_PROC; p++) begin : g_proc
    logic [NUM_IRQ-1:0] en_row, pend_row;
    logic               cand;
    logic [RUN_W-1:0]   win_prio;
    logic [ID_W-1:0]    win_id;

    assign en_row   = irq_enable[p*NUM_IRQ +: NUM_IRQ];
    assign pend_row = irq_pending[p*NUM_IRQ +: NUM_IRQ];
    assign cand     = en_row[cnt] & pend_row[cnt];

    irq_best_track u_track (
      .clk       (clk),
      .rst_n     (rst_s2_q),
      .first     (first),
      .cand      (cand),
      .cand_prio (cur_prio),
      .cand_id   (cur_id),
      .win_prio  (win_prio),
      .win_id    (win_id)
    );

    irq_req_gate u_gate (
      .allow    (dist_en & proc_en[p]),
      .win_prio (win_prio),
      .win_id   (win_id),
      .mask     (prio_mask[p*PRIO_W +: PRIO_W]),
      .run      (run_prio[p*RUN_W +: RUN_W]),
      .out_id   (gate_id[p*ID_W +: ID_W]),
      .out_req  (gate_req[p])
    );
  end

  // output registers, loaded once per sweep
  logic [NUM_PROC*ID_W-1:0] id_q, id_d;
  logic [NUM_PROC-1:0]      req_q, req_d;
  logic                     done_q, valid_q, valid_d;

  always_comb begin
    id_d    = id_q;
    req_d   = req_q;
    valid_d = valid_q;
    if (last) begin
      id_d    = gate_id;
      req_d   = gate_req;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s2_q) begin
    if (!rst_s2_q) begin
      id_q    <= {NUM_PROC{SPUR_ID}};
      req_q   <= '0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      id_q    <= id_d;
      req_q   <= req_d;
      done_q  <= last;
      valid_q <= valid_d;
    end
  end

  assign best_id      = id_q;
  assign irq_req      = req_q;
  assign scan_done    = done_q;
  assign result_valid = valid_q;
endmodule

// File: rtl/irq_prio_select_chk.sv
module irq_prio_select_chk
  import irq_sel_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int NUM_PROC = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      dist_en,
  input logic [NUM_PROC-1:0]       proc_en,
  input logic [NUM_PROC*ID_W-1:0]  best_id,
  input logic [NUM_PROC-1:0]       irq_req,
  input logic                      scan_done,
  input logic                      result_valid
);
  for (genvar p = 0; p < NUM_PROC; p++) begin : g_chk
    AST_REQ_NEEDS_ID: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[p] |-> (best_id[p*ID_W +: ID_W] != SPUR_ID)); // R4
    AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_done && !($past(dist_en) && $past(proc_en[p]))) |->
        (!irq_req[p] && best_id[p*ID_W +: ID_W] == SPUR_ID)); // R7
  end

  AST_HOLD_BETWEEN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_done |-> ($stable(best_id) && $stable(irq_req))); // R9
  AST_LOAD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done); // R9
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> result_valid); // R10
  AST_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> result_valid); // R10
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> (irq_req == '0)); // R10
endmodule

bind irq_prio_select irq_prio_select_chk #(
  .NUM_IRQ  (NUM_IRQ),
  .NUM_PROC (NUM_PROC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dist_en      (dist_en),
  .proc_en      (proc_en),
  .best_id      (best_id),
  .irq_req      (irq_req),
  .scan_done    (scan_done),
  .result_valid (result_valid)
);

// File: tb/irq_prio_select_bench.sv
module irq_prio_select_bench;
  localparam int NI = 64;
  localparam int NP = 4;
  localparam int SPUR = 1023;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              dist_en;
  logic [NP-1:0]     proc_en;
  logic [NP*NI-1:0]  en, pend;
  logic [NI*8-1:0]   prio;
  logic [NP*8-1:0]   mask;
  logic [NP*9-1:0]   run;
  logic [NP*10-1:0]  best_id;
  logic [NP-1:0]     irq_req;
  logic              scan_done, result_valid;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  irq_prio_select #(.NUM_IRQ(NI), .NUM_PROC(NP)) u_irq_prio_select (
    .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .proc_en(proc_en),
    .irq_enable(en), .irq_pending(pend), .irq_prio(prio),
    .prio_mask(mask), .run_prio(run), .best_id(best_id),
    .irq_req(irq_req), .scan_done(scan_done), .result_valid(result_valid)
  );

  function automatic int model_best(int p, output int bp);
    int id = SPUR;
    bp = 256;
    for (int i = 0; i < NI; i++)
      if (en[p*NI+i] && pend[p*NI+i] && int'(prio[i*8 +: 8]) < bp) begin
        bp = int'(prio[i*8 +: 8]);
        id = i;
      end
    return id;
  endfunction

  function automatic int exp_id(int p);
    int bp, id;
    id = model_best(p, bp);
    if (!dist_en || !proc_en[p]) return SPUR;
    if (bp < int'(mask[p*8 +: 8])) return id;
    return SPUR;
  endfunction

  function automatic bit exp_req(int p);
    int bp, id;
    id = model_best(p, bp);
    if (!dist_en || !proc_en[p]) return 1'b0;
    return (bp < int'(mask[p*8 +: 8])) && (bp < int'(run[p*9 +: 9]));
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_proc(int p, string tag);
    chk(tag, int'(best_id[p*10 +: 10]), exp_id(p));
    chk(tag, int'(irq_req[p]), int'(exp_req(p)));
  endtask

  task automatic settle();
    int seen = 0;
    int guard = 0;
    while (seen < 2 && guard < 4*NI + 10) begin
      @(negedge clk);
      if (scan_done) seen++;
      guard++;
    end
    if (seen < 2) chk("R9 load pulse", seen, 2);
  endtask

  task automatic clear_all();
    dist_en = 1'b1; proc_en = '1; en = '0; pend = '0; prio = '1;
    mask = '1; run = {NP{9'h100}};
  endtask

  task automatic set_irq(int p, int i, int pr);
    en[p*NI+i] = 1'b1; pend[p*NI+i] = 1'b1; prio[i*8 +: 8] = 8'(pr);
  endtask

  initial begin : watchdog
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int gap;
    int held_id;
    void'($urandom(32'h1234_5a5a));
    rst_n = 1'b0;
    clear_all();
    repeat (3) @(negedge clk);
    // R10 reset state
    for (int p = 0; p < NP; p++) chk("R10 reset id", int'(best_id[p*10 +: 10]), SPUR);
    chk("R10 reset req", int'(irq_req), 0);
    chk("R10 reset valid", int'(result_valid), 0);
    rst_n = 1'b1;
    settle();
    chk("R10 valid after sweep", int'(result_valid), 1);

    // R3 nothing pending
    for (int p = 0; p < NP; p++) check_proc(p, "R3");

    // R6 single irq with idle running priority
    set_irq(0, 5, 40);
    settle();
    chk("R6 id", int'(best_id[9:0]), 5);
    chk("R6 req", int'(irq_req[0]), 1);

    // R1 lower value wins
    set_irq(0, 2, 60); set_irq(0, 9, 10);
    settle();
    chk("R1 id", int'(best_id[9:0]), 9);

    // R2 tie resolves to lowest id
    set_irq(0, 7, 10); set_irq(0, 30, 10);
    settle();
    chk("R2 id", int'(best_id[9:0]), 7);

    // R4 mask equal to best priority hides it
    mask[7:0] = 8'd10;
    settle();
    chk("R4 id", int'(best_id[9:0]), SPUR);
    chk("R4 req", int'(irq_req[0]), 0);
    mask[7:0] = 8'd11;
    settle();
    chk("R4 id mask+1", int'(best_id[9:0]), 7);

    // R5 running priority threshold
    run[8:0] = 9'd10;
    settle();
    chk("R5 id reported", int'(best_id[9:0]), 7);
    chk("R5 req low", int'(irq_req[0]), 0);
    run[8:0] = 9'd11;
    settle();
    chk("R5 req high", int'(irq_req[0]), 1);

    // R7 gating
    dist_en = 1'b0;
    settle();
    for (int p = 0; p < NP; p++) check_proc(p, "R7 dist");
    dist_en = 1'b1; proc_en[0] = 1'b0;
    settle();
    chk("R7 proc id", int'(best_id[9:0]), SPUR);
    chk("R7 proc req", int'(irq_req[0]), 0);
    proc_en[0] = 1'b1;

    // R8 independent processors, boundary id at the end of the sweep
    clear_all();
    set_irq(1, NI-1, 3); set_irq(2, 0, 200); set_irq(3, 12, 4);
    en[3*NI+NI-1] = 1'b1; pend[3*NI+NI-1] = 1'b1;
    settle();
    for (int p = 0; p < NP; p++) check_proc(p, "R8");
    chk("R8 last id", int'(best_id[19:10]), NI-1);

    // R9 load spacing and hold between loads
    gap = 0;
    do begin @(negedge clk); gap++; end while (!scan_done && gap < 4*NI);
    held_id = int'(best_id[19:10]);
    pend[1*NI+NI-1] = 1'b0;
    gap = 0;
    do begin
      @(negedge clk); gap++;
      if (!scan_done) chk("R9 hold", int'(best_id[19:10]), held_id);
    end while (!scan_done && gap < 4*NI);
    chk("R9 spacing", gap, NI);
    settle();
    check_proc(1, "R9 update");

    // random rounds, all rules
    for (int r = 0; r < 80; r++) begin
      for (int k = 0; k < NP*NI; k++) begin
        en[k]   = ($urandom % 4) != 0;
        pend[k] = ($urandom % 6) == 0;
      end
      for (int i = 0; i < NI; i++) prio[i*8 +: 8] = 8'(($urandom % 6) * 16);
      for (int p = 0; p < NP; p++) begin
        mask[p*8 +: 8] = ($urandom % 3 == 0) ? 8'(($urandom % 6) * 16) : 8'hff;
        run[p*9 +: 9]  = ($urandom % 2 == 0) ? 9'h100 : 9'(($urandom % 6) * 16);
        proc_en[p]     = ($urandom % 8) != 0;
      end
      dist_en = ($urandom % 10) != 0;
      settle();
      for (int p = 0; p < NP; p++) check_proc(p, "R1 R2 R4 R5 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule